// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block derives the SCL waveform of an I2C master from the system clock. A power-of-two prescaler produces a tick every 2^base cycles. Separate low-phase and high-phase counters measure each half of the SCL period in ticks. The generator therefore asks for SCL to be pulled low for (low+1) ticks and then released for (high+1) ticks. As a result, one SCL period lasts 2^base × ((high+1) + (low+1)) system clocks.

All settings live in one 32-bit timing register. Two write strobes update it. A full write loads everything. A divisor write touches only the exponent and the two phase counts, so the bus-free, start-hold and setup fields in the top twelve bits survive it. Around the counters the block provides strobes for the byte engine:
- a warning in the last cycle before SCL is released;
- a warning in the last cycle before SCL is pulled low;
- a single sampling strobe near the middle of the high phase.

A released SCL that still reads low is treated as clock stretching by a target. During stretching the high-phase count and the prescaler wait.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset the timing register reads zero, `scl_drive_low` and `phase_high` are 0, and `tick`, `rise_next`, `fall_next` and `mid_strobe` are 0.
- R2: A full write (`tmr_wr_all`) stores data bits 31:20, 19:16, 15:12 and 3:0. Bits 11:4 always read back as zero.
- R3: A divisor write (`tmr_wr_div`) changes only the high count (bits 19:16), the low count (bits 15:12) and the exponent (bits 3:0). Bits 31:20 keep their value. When both strobes are high in one cycle, the full write wins.
- R4: While running and not stretched, `tick` is a one-cycle pulse every 2^base cycles.
- R5: When `enable` rises, one idle cycle follows. Then `scl_drive_low` is 1 for (low+1)·2^base cycles. Then `phase_high` is 1 (SCL released) for (high+1)·2^base cycles. The two phases alternate for as long as `enable` stays high.
- R6: A count of zero in either field still yields a phase of exactly one tick.
- R7: `rise_next` is high exactly once per low phase, in its final cycle. `fall_next` is high exactly once per high phase, in its final cycle.
- R8: `mid_strobe` is high exactly once per high phase. It fires ((high+1)>>1)·2^base cycles after the phase starts, plus any stretch cycles that came before it.
- R9: During the high phase, every cycle in which `scl_in` reads low raises `stretch`. In such a cycle the prescaler and the high counter hold, which lengthens the high phase by one cycle.
- R10: One cycle after `enable` falls, `scl_drive_low`, `phase_high` and `tick` are 0. A later enable starts again with a complete low phase.
- R11: Any register write restarts the prescaler. If the write strobe is sampled in cycle W, the next tick comes in cycle W+2^base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low releases SCL and clears the counters |
| tmr_wr_all | input | 1 | Write all stored fields of the timing register |
| tmr_wr_div | input | 1 | Write only the exponent and the phase counts |
| tmr_wdata | input | 32 | Write data for the timing register |
| scl_in | input | 1 | Sampled level of the SCL line |
| timing_q | output | 32 | Current timing register contents |
| tick | output | 1 | Prescaled tick |
| phase_high | output | 1 | SCL is in its released (high) phase |
| scl_drive_low | output | 1 | Request to pull SCL low |
| rise_next | output | 1 | SCL will be released in the next cycle |
| fall_next | output | 1 | SCL will be pulled low in the next cycle |
| mid_strobe | output | 1 | Sampling point inside the high phase |
| stretch | output | 1 | Released SCL still reads low; counting waits |

## Verification
A wrong phase counter or state shows up at the next phase boundary. The measured length of the low or high half-period then differs from the programmed one, and the warning strobe is missing from the final cycle or appears twice. A prescaler that fails to wrap or restart moves the next `tick` away from its 2^base spacing within one tick period. A stretch that does not freeze the counter shortens the stretched high phase by the stall count. A register that merges a divisor write wrongly is exposed on `timing_q` in the cycle after the strobe.

// File: rtl/scl_tg_pkg.sv
`timescale 1ns/1ps
package scl_tg_pkg;

   // Phase of the generated clock; IDLE only while disabled or just enabled.
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } scl_phase_e;

   // Default layout of the timing register.
   localparam int TG_REG_W     = 32;
   localparam int TG_BASE_LSB  = 0;
   localparam int TG_LOW_LSB   = 12;
   localparam int TG_HIGH_LSB  = 16;
   localparam int TG_EXTRA_LSB = 20;

endpackage

// File: rtl/scl_tg_cfg.sv
`timescale 1ns/1ps
module scl_tg_cfg #(
   parameter int REG_W     = 32,
   parameter int CNT_W     = 4,
   parameter int BASE_W    = 4,
   parameter int BASE_LSB  = 0,
   parameter int LOW_LSB   = 12,
   parameter int HIGH_LSB  = 16,
   parameter int EXTRA_LSB = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_all,
   input  logic              wr_div,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  q,
   output logic [BASE_W-1:0] base,
   output logic [CNT_W-1:0]  high_cnt,
   output logic [CNT_W-1:0]  low_cnt,
   output logic              wr_any
);

   localparam logic [REG_W-1:0] BASE_M  = REG_W'(((64'd1 << BASE_W) - 64'd1) << BASE_LSB);
   localparam logic [REG_W-1:0] LOW_M   = REG_W'(((64'd1 << CNT_W) - 64'd1) << LOW_LSB);
   localparam logic [REG_W-1:0] HIGH_M  = REG_W'(((64'd1 << CNT_W) - 64'd1) << HIGH_LSB);
   localparam logic [REG_W-1:0] EXTRA_M = REG_W'(~64'd0 << EXTRA_LSB);
   localparam logic [REG_W-1:0] DIV_M   = BASE_M | LOW_M | HIGH_M;
   localparam logic [REG_W-1:0] KEEP_M  = DIV_M | EXTRA_M;

   logic [REG_W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= '0;
      end else if (wr_all) begin
         q_r <= wdata & KEEP_M;
      end else if (wr_div) begin
         q_r <= (q_r & ~DIV_M) | (wdata & DIV_M);
      end
   end

   assign q        = q_r;
   assign base     = q_r[BASE_LSB +: BASE_W];
   assign high_cnt = q_r[HIGH_LSB +: CNT_W];
   assign low_cnt  = q_r[LOW_LSB +: CNT_W];
   assign wr_any   = wr_all | wr_div;

   // R3: the upper timing fields survive a divisor-only write.
   a_r3_extra_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_div && !wr_all) |=> ((q & EXTRA_M) == $past(q & EXTRA_M)));

endmodule

// File: rtl/scl_tg_prescale.sv
`timescale 1ns/1ps
module scl_tg_prescale #(
   parameter int BASE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [BASE_W-1:0] base,
   output logic              tick,
   output logic              first
);

   // Largest exponent is 2^BASE_W-1, so the limit needs that many bits.
   localparam int PRE_W = (1 << BASE_W) - 1;

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] lim;

   assign lim = ~({PRE_W{1'b1}} << base);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !run) begin
         cnt_q <= '0;
      end else if (cnt_q == lim) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + PRE_W'(1);
      end
   end

   assign tick  = run && (cnt_q == lim);
   assign first = (cnt_q == '0);

   // R4: with a divide ratio above one, ticks never come back to back.
   a_r4_tick_single : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && (lim != '0)) |=> !tick);

   // R11: a restart leaves the divider at its first count.
   a_r11_restart_first : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> first);

endmodule

// File: rtl/scl_tg_phase.sv
`timescale 1ns/1ps
module scl_tg_phase
   import scl_tg_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             first,
   input  logic [CNT_W-1:0] high_cnt,
   input  logic [CNT_W-1:0] low_cnt,
   input  logic             scl_in,
   output logic             drive_low,
   output logic             phase_high,
   output logic             rise_next,
   output logic             fall_next,
   output logic             mid_strobe,
   output logic             stretched,
   output logic             hold
);

   scl_phase_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             line_low;
   logic [CNT_W:0]   mid_tgt;
   logic             low_done;
   logic             high_done;

   // The variant picks whether a low line may hold off the high phase.
   generate
      if (STRETCH_EN) begin : g_stretch
         assign line_low = ~scl_in;
      end else begin : g_no_stretch
         logic unused_scl;
         assign unused_scl = scl_in;
         assign line_low   = 1'b0;
      end
   endgenerate

   assign stretched = (st_q == PH_HIGH) && line_low;
   assign hold      = (st_q == PH_IDLE) || stretched;
   assign low_done  = (cnt_q == low_cnt);
   assign high_done = (cnt_q == high_cnt);
   assign mid_tgt   = ({1'b0, high_cnt} + (CNT_W+1)'(1)) >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PH_IDLE;
         cnt_q <= '0;
      end else if (!en) begin
         st_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            PH_IDLE: begin
               st_q  <= PH_LOW;
               cnt_q <= '0;
            end
            PH_LOW: begin
               if (tick) begin
                  if (low_done) begin
                     st_q  <= PH_HIGH;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            PH_HIGH: begin
               if (tick) begin
                  if (high_done) begin
                     st_q  <= PH_LOW;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            default: begin
               st_q  <= PH_IDLE;
               cnt_q <= '0;
            end
         endcase
      end
   end

   assign drive_low  = (st_q == PH_LOW);
   assign phase_high = (st_q == PH_HIGH);
   assign rise_next  = (st_q == PH_LOW) && tick && low_done;
   assign fall_next  = (st_q == PH_HIGH) && tick && high_done;
   assign mid_strobe = (st_q == PH_HIGH) && !stretched && first &&
                       ({1'b0, cnt_q} == mid_tgt);

   // R7: the warning strobes are followed by the announced edge.
   a_r7_rise_then_release : assert property (@(posedge clk) disable iff (!rst_n)
      (rise_next && en) |=> (!drive_low && phase_high));
   a_r7_fall_then_drive : assert property (@(posedge clk) disable iff (!rst_n)
      (fall_next && en) |=> drive_low);
   a_r7_edges_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_next && fall_next));

   // R9: a stretched cycle does not advance the high count.
   a_r9_stretch_freeze : assert property (@(posedge clk) disable iff (!rst_n)
      (stretched && en) |=> (cnt_q == $past(cnt_q)));

   // R10: disabling releases the line one cycle later.
   a_r10_disable_release : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!drive_low && !phase_high));

endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
   import scl_tg_pkg::*;
#(
   parameter int REG_W      = TG_REG_W,
   parameter int CNT_W      = 4,
   parameter int BASE_W     = 4,
   parameter int BASE_LSB   = TG_BASE_LSB,
   parameter int LOW_LSB    = TG_LOW_LSB,
   parameter int HIGH_LSB   = TG_HIGH_LSB,
   parameter int EXTRA_LSB  = TG_EXTRA_LSB,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tmr_wr_all,
   input  logic             tmr_wr_div,
   input  logic [REG_W-1:0] tmr_wdata,
   input  logic             scl_in,
   output logic [REG_W-1:0] timing_q,
   output logic             tick,
   output logic             phase_high,
   output logic             scl_drive_low,
   output logic             rise_next,
   output logic             fall_next,
   output logic             mid_strobe,
   output logic             stretch
);

   // Elaboration-time checks on the field layout.
   generate
      if (BASE_W < 1 || BASE_W > 5) begin : g_bad_base_w
         $error("BASE_W must lie in 1..5");
      end
      if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt_w
         $error("CNT_W must lie in 1..8");
      end
      if (BASE_LSB + BASE_W > LOW_LSB) begin : g_bad_base_pos
         $error("exponent field overlaps low count");
      end
      if (LOW_LSB + CNT_W > HIGH_LSB) begin : g_bad_low_pos
         $error("low count overlaps high count");
      end
      if (HIGH_LSB + CNT_W > EXTRA_LSB || EXTRA_LSB >= REG_W) begin : g_bad_high_pos
         $error("high count overlaps the upper timing fields");
      end
   endgenerate

   logic [BASE_W-1:0] base;
   logic [CNT_W-1:0]  high_cnt;
   logic [CNT_W-1:0]  low_cnt;
   logic              wr_any;
   logic              hold;
   logic              run;
   logic              first;

   scl_tg_cfg #(
      .REG_W     (REG_W),
      .CNT_W     (CNT_W),
      .BASE_W    (BASE_W),
      .BASE_LSB  (BASE_LSB),
      .LOW_LSB   (LOW_LSB),
      .HIGH_LSB  (HIGH_LSB),
      .EXTRA_LSB (EXTRA_LSB)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_all   (tmr_wr_all),
      .wr_div   (tmr_wr_div),
      .wdata    (tmr_wdata),
      .q        (timing_q),
      .base     (base),
      .high_cnt (high_cnt),
      .low_cnt  (low_cnt),
      .wr_any   (wr_any)
   );

   assign run = enable && !hold;

   scl_tg_prescale #(
      .BASE_W (BASE_W)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (wr_any),
      .base    (base),
      .tick    (tick),
      .first   (first)
   );

   scl_tg_phase #(
      .CNT_W      (CNT_W),
      .STRETCH_EN (STRETCH_EN)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (enable),
      .tick       (tick),
      .first      (first),
      .high_cnt   (high_cnt),
      .low_cnt    (low_cnt),
      .scl_in     (scl_in),
      .drive_low  (scl_drive_low),
      .phase_high (phase_high),
      .rise_next  (rise_next),
      .fall_next  (fall_next),
      .mid_strobe (mid_strobe),
      .stretched  (stretch),
      .hold       (hold)
   );

endmodule

// File: tb/scl_timing_gen_tb.sv
`timescale 1ns/1ps
module scl_timing_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        tmr_wr_all = 1'b0;
   logic        tmr_wr_div = 1'b0;
   logic [31:0] tmr_wdata = '0;
   logic        force_low = 1'b0;
   logic        scl_in;
   logic [31:0] timing_q;
   logic        tick, phase_high, scl_drive_low, rise_next, fall_next;
   logic        mid_strobe, stretch;

   always #4 clk = ~clk;   // 125 MHz

   // Open-drain line: low when the block drives it or a target stretches it.
   assign scl_in = !scl_drive_low && !force_low;

   scl_timing_gen u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .tmr_wr_all    (tmr_wr_all),
      .tmr_wr_div    (tmr_wr_div),
      .tmr_wdata     (tmr_wdata),
      .scl_in        (scl_in),
      .timing_q      (timing_q),
      .tick          (tick),
      .phase_high    (phase_high),
      .scl_drive_low (scl_drive_low),
      .rise_next     (rise_next),
      .fall_next     (fall_next),
      .mid_strobe    (mid_strobe),
      .stretch       (stretch)
   );

   typedef struct {
      bit    is_high;
      int    len;
      int    mid;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_err = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic write_all(input logic [31:0] d);
      tmr_wdata  = d;
      tmr_wr_all = 1'b1;
      step();
      tmr_wr_all = 1'b0;
   endtask

   task automatic write_div(input logic [31:0] d);
      tmr_wdata  = d;
      tmr_wr_div = 1'b1;
      step();
      tmr_wr_div = 1'b0;
   endtask

   // Driver: program, push the expected phases, run until all are seen.
   task automatic run_cfg(input int b, input int h, input int l, input int nper,
                          input int stall, input string tag);
      int t = 1 << b;
      logic [3:0] b4 = b[3:0];
      logic [3:0] h4 = h[3:0];
      logic [3:0] l4 = l[3:0];
      write_all({12'h000, h4, l4, 8'h00, b4});
      for (int p = 0; p < nper; p++) begin
         int extra = (p == 0) ? stall : 0;
         exp_q.push_back('{1'b0, (l + 1) * t, 0, tag});
         exp_q.push_back('{1'b1, (h + 1) * t + extra, ((h + 1) >> 1) * t + extra,
                           (extra > 0) ? "R9" : tag});
      end
      force_low = (stall > 0);
      enable    = 1'b1;
      if (stall > 0) begin
         while (!phase_high) step();
         chk(stretch == 1'b1, "R9", stretch, 1);
         repeat (stall) step();
         force_low = 1'b0;
      end
      while (exp_q.size() > 0) step();
      enable = 1'b0;
      step();
      step();
   endtask

   // Monitor: measure each completed phase and compare with the queue.
   int   prv = 0;
   int   cur;
   int   run_len = 0;
   int   edge_n = 0;
   bit   edge_last = 1'b0;
   int   mid_n = 0;
   int   mid_at = -1;
   exp_t it;

   always @(negedge clk) begin
      if (rst_n) begin
         cur = scl_drive_low ? 1 : (phase_high ? 2 : 0);
         if (cur != prv) begin
            if (prv != 0 && cur != 0 && exp_q.size() > 0) begin
               it = exp_q.pop_front();
               chk(it.is_high == (prv == 2), "R5", prv, it.is_high ? 2 : 1);
               chk(run_len == it.len, it.tag, run_len, it.len);
               chk(edge_last && edge_n == 1, "R7", edge_n, 1);
               if (prv == 2) begin
                  chk(mid_n == 1 && mid_at == it.mid, "R8", mid_at, it.mid);
               end
            end
            run_len = 0;
            edge_n  = 0;
            mid_n   = 0;
            mid_at  = -1;
         end
         edge_last = (cur == 1) ? rise_next : ((cur == 2) ? fall_next : 1'b0);
         if (edge_last) edge_n++;
         if (cur == 2 && mid_strobe) begin
            mid_n++;
            mid_at = run_len;
         end
         run_len++;
         prv = cur;
      end
   end

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk(timing_q == 32'h0, "R1", timing_q, 0);
      chk(!scl_drive_low && !phase_high, "R1", {scl_drive_low, phase_high}, 0);
      chk(!tick && !rise_next && !fall_next && !mid_strobe, "R1",
          {tick, rise_next, fall_next, mid_strobe}, 0);

      // R2: full write keeps stored fields, bits 11:4 read zero
      write_all(32'hFFFF_FFFF);
      chk(timing_q == 32'hFFFF_F00F, "R2", timing_q, 32'hFFFF_F00F);
      write_all(32'hA5A5_A5A5);
      chk(timing_q == 32'hA5A5_A005, "R2", timing_q, 32'hA5A5_A005);

      // R3: divisor write leaves bits 31:20 alone
      write_div(32'h5A53_7FF2);
      chk(timing_q == 32'hA5A3_7002, "R3", timing_q, 32'hA5A3_7002);
      tmr_wr_div = 1'b1;
      write_all(32'h1234_5678);
      tmr_wr_div = 1'b0;
      chk(timing_q == 32'h1234_5008, "R3", timing_q, 32'h1234_5008);

      // R5, R6, R7, R8: several timing settings
      run_cfg(0, 0, 0, 3, 0, "R6");
      run_cfg(1, 3, 5, 2, 0, "R5");
      run_cfg(3, 15, 0, 2, 0, "R6");
      run_cfg(0, 2, 7, 2, 0, "R5");
      // R9: first high phase stretched by five cycles
      run_cfg(1, 3, 1, 2, 5, "R5");

      // R4: tick spacing at 2^2
      write_all({12'h000, 4'd1, 4'd1, 8'h00, 4'd2});
      enable = 1'b1;
      while (!tick) step();
      for (int k = 0; k < 3; k++) begin
         n = 0;
         do begin
            step();
            n++;
         end while (!tick);
         chk(n == 4, "R4", n, 4);
      end

      // R11: a write one cycle after a tick restarts the divider
      step();
      tmr_wdata  = {12'h000, 4'd1, 4'd1, 8'h00, 4'd2};
      tmr_wr_div = 1'b1;
      step();
      tmr_wr_div = 1'b0;
      chk(!tick, "R11", tick, 0);
      n = 0;
      do begin
         step();
         n++;
      end while (!tick && n < 20);
      chk(n == 3, "R11", n, 3);

      // R10: disable in the middle of a low phase
      while (!scl_drive_low) step();
      step();
      enable = 1'b0;
      step();
      chk(!scl_drive_low && !phase_high, "R10", {scl_drive_low, phase_high}, 0);
      chk(!tick, "R10", tick, 0);
      run_cfg(1, 3, 5, 1, 0, "R10");

      finish_run();
   end

endmodule